// File: doc/BRIEF.md
# Per-channel waveform feature extractor

This block reduces the fixed window of digitized samples taken for one readout channel to a short record of 16-bit words. A window arrives as a stream of sample beats under a valid/ready handshake. The first beat carries a start mark and the channel tag, and the last beat carries an end mark. While the beats go by, the block adds up the charge above a programmable pedestal. It also notes the sample position of every rising crossing of a programmable threshold.

Once the window closes, the block emits a record of three parts, in this order:
- a status word holding the channel, the hit count and two flag bits;
- the integrated charge;
- one word per recorded crossing.

The record is sent on consecutive cycles. Every window yields a record, even one with no crossings, so the downstream concentrator always sees one record per channel and in arrival order. The sample input is held off until the last word of the record has left. This keeps the records in order and lets a single set of accumulators serve every channel.

The raw window is 32 bytes. A typical record is a few words long.

Top module: `fx_wave_reducer`

## Requirements
- R1: A sample beat is taken when in_valid and in_ready are both high. in_ready goes low on the cycle after the end-marked beat is taken, and stays low until the cycle after the last record word. Beats offered while in_ready is low have no effect on any record.
- R2: A record begins on the cycle right after the end-marked beat is taken, and its words appear on consecutive cycles with out_valid high. out_sor is high on the first word only and out_eor on the last word only. The record length is 2 plus the hit count, and out_valid is low between records.
- R3: Word 0 is the status word. Bit 15 is the truncation flag, bit 14 the charge-saturation flag, bits 13:10 the hit count and bits 9:0 the channel tag (zero-extended).
- R4: Word 1 is the charge. It is the sum over the window of (sample - pedestal) for every sample above the pedestal; samples at or below the pedestal add nothing.
- R5: The charge saturates at 65535. The saturation flag is set when the true sum exceeds 65535.
- R6: A hit is a sample strictly above the threshold whose predecessor in the same window is not above it. The first sample of a window counts as a hit when it is above. Hit words follow the charge in ascending order and carry the sample position (0 = start-marked beat) in bits 4:0, with the other bits zero.
- R7: At most 8 hit words are emitted. Further crossings set the truncation flag, and the hit count stays at 8.
- R8: A window with no crossing still yields a two-word record: status with hit count 0, then charge.
- R9: The channel tag is captured on the start-marked beat. A start-marked beat discards any window in progress and restarts position, charge and hits.
- R10: During and right after reset, in_ready is high and out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample beat offered |
| in_ready | output | 1 | Block can take a beat |
| in_sample | input | SAMP_W | Sample value |
| in_chan | input | CH_W | Channel tag, used on start-marked beat |
| in_sow | input | 1 | First beat of a window |
| in_eow | input | 1 | Last beat of a window |
| thr | input | SAMP_W | Hit threshold |
| ped | input | SAMP_W | Charge pedestal |
| out_valid | output | 1 | Record word present |
| out_word | output | 16 | Record word |
| out_sor | output | 1 | First word of record |
| out_eor | output | 1 | Last word of record |

## Verification
A wrong window position or a stale crossing flag shows up in the very next record as a hit word with the wrong index, or as a missing or extra hit. A hit count that is off changes both the status field and the record length, so out_eor lands on the wrong cycle and in_ready returns one cycle early or late. A charge accumulator that is not cleared on the start beat leaves the charge word wrong in that same record. Because every output is compared against a behavioural model on every clock, each of these faults is seen within one record of the window that caused it. A second instance with wider samples drives the saturation boundary.

// File: rtl/fx_pkg.sv
package fx_pkg;
  localparam int WORD_W       = 16;
  localparam int CHAN_FIELD_W = 10;
  localparam int CNT_FIELD_W  = 4;

  // per-sample charge contribution: amount above pedestal, never negative
  function automatic logic [WORD_W-1:0] clamp_excess(input logic [WORD_W-1:0] smp,
                                                     input logic [WORD_W-1:0] base);
    return (smp > base) ? smp - base : '0;
  endfunction

  // saturating add; top bit reports that the true sum overflowed
  function automatic logic [WORD_W:0] add_sat(input logic [WORD_W-1:0] acc,
                                              input logic [WORD_W-1:0] inc);
    logic [WORD_W:0] s;
    s = {1'b0, acc} + {1'b0, inc};
    if (s[WORD_W]) return {1'b1, {WORD_W{1'b1}}};
    return s;
  endfunction

  function automatic logic [WORD_W-1:0] pack_status(input logic trunc,
                                                    input logic sat,
                                                    input logic [CNT_FIELD_W-1:0] cnt,
                                                    input logic [CHAN_FIELD_W-1:0] chan);
    return {trunc, sat, cnt, chan};
  endfunction
endpackage

// File: rtl/fx_charge_acc.sv
module fx_charge_acc import fx_pkg::*; #(
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat,
  input  logic              sow,
  input  logic [SAMP_W-1:0] smp,
  input  logic [SAMP_W-1:0] ped,
  output logic [WORD_W-1:0] charge,
  output logic              sat
);
  logic [WORD_W:0] nxt;

  always_comb nxt = add_sat(sow ? '0 : charge, clamp_excess(WORD_W'(smp), WORD_W'(ped)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      charge <= '0;
      sat    <= 1'b0;
    end else if (beat) begin
      charge <= nxt[WORD_W-1:0];
      sat    <= (sow ? 1'b0 : sat) | nxt[WORD_W];
    end
  end
endmodule

// File: rtl/fx_hit_finder.sv
module fx_hit_finder #(
  parameter int SAMP_W   = 8,
  parameter int MAX_HITS = 8,
  parameter int IDX_W    = 5,
  parameter int CNT_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat,
  input  logic                      sow,
  input  logic [SAMP_W-1:0]         smp,
  input  logic [SAMP_W-1:0]         thr,
  output logic [CNT_W-1:0]          hit_cnt,
  output logic                      trunc,
  output logic [MAX_HITS*IDX_W-1:0] hit_list
);
  logic [IDX_W-1:0] idx, cur_idx;
  logic [CNT_W-1:0] base_cnt;
  logic             prev_above, above, base_trunc, room, crossing;

  always_comb begin
    above      = smp > thr;
    cur_idx    = sow ? '0 : idx;
    base_cnt   = sow ? '0 : hit_cnt;
    base_trunc = sow ? 1'b0 : trunc;
    crossing   = beat && above && (sow || !prev_above);
    room       = base_cnt < CNT_W'(MAX_HITS);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      prev_above <= 1'b0;
      hit_cnt    <= '0;
      trunc      <= 1'b0;
    end else if (beat) begin
      idx        <= cur_idx + 1'b1;
      prev_above <= above;
      hit_cnt    <= (crossing && room) ? base_cnt + 1'b1 : base_cnt;
      trunc      <= base_trunc | (crossing && !room);
    end
  end

  // one slot register per possible hit; slot g is written by the g-th crossing
  for (genvar g = 0; g < MAX_HITS; g++) begin : g_slot
    logic [IDX_W-1:0] pos_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= '0;
      else if (crossing && base_cnt == CNT_W'(g)) pos_q <= cur_idx;
    end
    assign hit_list[g*IDX_W +: IDX_W] = pos_q;
  end
endmodule

// File: rtl/fx_record_emit.sv
module fx_record_emit import fx_pkg::*; #(
  parameter int CH_W     = 6,
  parameter int IDX_W    = 5,
  parameter int MAX_HITS = 8,
  parameter int CNT_W    = 4,
  parameter int PTR_W    = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      beat,
  input  logic                      sow,
  input  logic                      eow,
  input  logic [CH_W-1:0]           chan,
  input  logic [WORD_W-1:0]         charge,
  input  logic                      sat,
  input  logic [CNT_W-1:0]          hit_cnt,
  input  logic                      trunc,
  input  logic [MAX_HITS*IDX_W-1:0] hit_list,
  output logic                      busy,
  output logic [WORD_W-1:0]         out_word,
  output logic                      out_sor,
  output logic                      out_eor
);
  logic [CH_W-1:0]  chan_q;
  logic [PTR_W-1:0] ptr;
  logic             last;

  always_comb last = busy && (ptr == PTR_W'(hit_cnt) + PTR_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      ptr    <= '0;
      chan_q <= '0;
    end else begin
      if (beat && sow) chan_q <= chan;
      if (beat && eow) begin
        busy <= 1'b1;
        ptr  <= '0;
      end else if (busy) begin
        if (last) busy <= 1'b0;
        else      ptr  <= ptr + 1'b1;
      end
    end
  end

  always_comb begin
    out_word = '0;
    if (ptr == '0)
      out_word = pack_status(trunc, sat, CNT_FIELD_W'(hit_cnt), CHAN_FIELD_W'(chan_q));
    else if (ptr == PTR_W'(1))
      out_word = charge;
    else
      for (int k = 0; k < MAX_HITS; k++)
        if (ptr == PTR_W'(k + 2)) out_word = WORD_W'(hit_list[k*IDX_W +: IDX_W]);
  end

  assign out_sor = busy && (ptr == '0);
  assign out_eor = last;
endmodule

// File: rtl/fx_wave_reducer.sv
module fx_wave_reducer import fx_pkg::*; #(
  parameter int SAMP_W   = 8,
  parameter int CH_W     = 6,
  parameter int WIN_LEN  = 32,
  parameter int MAX_HITS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [SAMP_W-1:0] in_sample,
  input  logic [CH_W-1:0]   in_chan,
  input  logic              in_sow,
  input  logic              in_eow,
  input  logic [SAMP_W-1:0] thr,
  input  logic [SAMP_W-1:0] ped,
  output logic              out_valid,
  output logic [15:0]       out_word,
  output logic              out_sor,
  output logic              out_eor
);
  localparam int IDX_W = $clog2(WIN_LEN);
  localparam int CNT_W = $clog2(MAX_HITS + 1);
  localparam int PTR_W = $clog2(MAX_HITS + 2);

  logic                      beat, win_close, busy, sat, trunc;
  logic [WORD_W-1:0]         charge;
  logic [CNT_W-1:0]          hit_cnt;
  logic [MAX_HITS*IDX_W-1:0] hit_list;

  assign in_ready  = !busy;
  assign beat      = in_valid && in_ready;
  assign win_close = beat && in_eow;
  assign out_valid = busy;

  fx_charge_acc #(.SAMP_W(SAMP_W)) u_acc (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sow(in_sow),
    .smp(in_sample), .ped(ped), .charge(charge), .sat(sat)
  );

  fx_hit_finder #(.SAMP_W(SAMP_W), .MAX_HITS(MAX_HITS), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_hits (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sow(in_sow), .smp(in_sample), .thr(thr),
    .hit_cnt(hit_cnt), .trunc(trunc), .hit_list(hit_list)
  );

  fx_record_emit #(.CH_W(CH_W), .IDX_W(IDX_W), .MAX_HITS(MAX_HITS), .CNT_W(CNT_W),
                   .PTR_W(PTR_W)) u_emit (
    .clk(clk), .rst_n(rst_n), .beat(beat), .sow(in_sow), .eow(in_eow), .chan(in_chan),
    .charge(charge), .sat(sat), .hit_cnt(hit_cnt), .trunc(trunc), .hit_list(hit_list),
    .busy(busy), .out_word(out_word), .out_sor(out_sor), .out_eor(out_eor)
  );
endmodule

module fx_wave_reducer_chk #(
  parameter int MAX_HITS = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        win_close,
  input logic        out_valid,
  input logic [15:0] out_word,
  input logic        out_sor,
  input logic        out_eor
);
  a_r1_hold_off: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !in_ready);
  a_r2_record_start: assert property (@(posedge clk) disable iff (!rst_n)
    win_close |=> (out_valid && out_sor));
  a_r2_record_end: assert property (@(posedge clk) disable iff (!rst_n)
    out_eor |=> !out_valid);
  a_r2_sor_qualified: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sor || out_eor) |-> out_valid);
  a_r2_rise_is_sor: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> out_sor);
  a_r8_min_length: assert property (@(posedge clk) disable iff (!rst_n)
    out_sor |=> (out_valid && !out_sor));
  a_r7_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
    out_sor |-> (out_word[13:10] <= 4'(MAX_HITS)));
  a_r7_trunc_full: assert property (@(posedge clk) disable iff (!rst_n)
    (out_sor && out_word[15]) |-> (out_word[13:10] == 4'(MAX_HITS)));
endmodule

bind fx_wave_reducer fx_wave_reducer_chk #(.MAX_HITS(MAX_HITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .win_close(win_close),
  .out_valid(out_valid), .out_word(out_word), .out_sor(out_sor), .out_eor(out_eor)
);

// File: tb/sim_fx_wave_reducer.sv
module sim_fx_wave_reducer;
  localparam int CLK_PERIOD = 10;
  localparam int CH_W = 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic            in_valid = 1'b0, in_sow = 1'b0, in_eow = 1'b0;
  logic [7:0]      in_sample = '0, thr = '0, ped = '0;
  logic [CH_W-1:0] in_chan = '0;
  logic            in_ready, out_valid, out_sor, out_eor;
  logic [15:0]     out_word;
  logic [11:0]     s1, thr1, ped1;
  logic            in_ready1, out_valid1, out_sor1, out_eor1;
  logic [15:0]     out_word1;

  // wide instance sees every value scaled by 16 (+15): same crossings, charge x16
  assign s1   = {in_sample, 4'hF};
  assign thr1 = {thr, 4'hF};
  assign ped1 = {ped, 4'hF};

  fx_wave_reducer u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sample(in_sample), .in_chan(in_chan), .in_sow(in_sow), .in_eow(in_eow), .thr(thr),
    .ped(ped), .out_valid(out_valid), .out_word(out_word), .out_sor(out_sor), .out_eor(out_eor));

  fx_wave_reducer #(.SAMP_W(12)) u1 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .in_ready(in_ready1), .in_sample(s1), .in_chan(in_chan), .in_sow(in_sow), .in_eow(in_eow),
    .thr(thr1), .ped(ped1), .out_valid(out_valid1), .out_word(out_word1), .out_sor(out_sor1),
    .out_eor(out_eor1));

  int n_checks = 0, n_fail = 0;
  bit done = 0;
  string phase = "R2";

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- reference model ----------------
  logic [17:0] q0[$], q1[$];
  string       qt[$];
  int m_idx, m_charge, m_chan;
  bit m_prev, m_trunc;
  int m_hits[$];

  task automatic push_rec();
    int n, c0, c1, st;
    n  = m_hits.size();
    c0 = (m_charge > 65535) ? 65535 : m_charge;
    c1 = (m_charge * 16 > 65535) ? 65535 : m_charge * 16;
    st = (int'(m_trunc) << 15) | (n << 10) | m_chan;
    q0.push_back({2'b10, 16'(st | ((m_charge > 65535) ? 32'h4000 : 0))});
    q1.push_back({2'b10, 16'(st | ((m_charge * 16 > 65535) ? 32'h4000 : 0))});
    qt.push_back({"R3/", phase});
    q0.push_back({1'b0, n == 0, 16'(c0)});
    q1.push_back({1'b0, n == 0, 16'(c1)});
    qt.push_back({"R4/R5/", phase});
    for (int i = 0; i < n; i++) begin
      q0.push_back({1'b0, i == n - 1, 16'(m_hits[i])});
      q1.push_back({1'b0, i == n - 1, 16'(m_hits[i])});
      qt.push_back({"R6/", phase});
    end
  endtask

  task automatic take_beat();
    if (in_sow) begin
      m_idx = 0; m_charge = 0; m_trunc = 0; m_prev = 0; m_chan = int'(in_chan);
      m_hits.delete();
    end
    if (in_sample > thr && !m_prev) begin
      if (m_hits.size() < 8) m_hits.push_back(m_idx % 32);
      else m_trunc = 1;
    end
    m_prev = in_sample > thr;
    if (in_sample > ped) m_charge += int'(in_sample) - int'(ped);
    m_idx++;
    if (in_eow) push_rec();
  endtask

  always @(negedge clk) begin
    #2;
    if (rst_n && !done) begin
      bit exp_rdy;
      logic [17:0] e0, e1;
      string t;
      exp_rdy = (q0.size() == 0);
      check(in_ready == exp_rdy, "R1", "in_ready u0", in_ready, exp_rdy);
      check(in_ready1 == exp_rdy, "R1", "in_ready u1", in_ready1, exp_rdy);
      if (q0.size() > 0) begin
        e0 = q0.pop_front(); e1 = q1.pop_front(); t = qt.pop_front();
        check({out_valid, out_sor, out_eor, out_word} == {1'b1, e0}, t, "u0 word",
              {out_valid, out_sor, out_eor, out_word}, {1'b1, e0});
        check({out_valid1, out_sor1, out_eor1, out_word1} == {1'b1, e1}, t, "u1 word",
              {out_valid1, out_sor1, out_eor1, out_word1}, {1'b1, e1});
      end else begin
        check(!out_valid && !out_valid1, "R2", "idle out_valid", {out_valid, out_valid1}, 0);
      end
      if (in_valid && exp_rdy) take_beat();
    end
  end

  // ---------------- drivers ----------------
  task automatic beat(input int s, input bit sow, input bit eow, input int ch, input bit gaps);
    do begin @(negedge clk); #1; end while (!in_ready);
    if (gaps && $urandom_range(0, 3) == 0) begin
      in_valid = 0;
      do begin @(negedge clk); #1; end while (!in_ready);
    end
    in_valid = 1; in_sample = 8'(s); in_sow = sow; in_eow = eow; in_chan = CH_W'(ch);
  endtask

  task automatic release_bus();
    @(negedge clk); #1;
    in_valid = 0; in_sow = 0; in_eow = 0;
  endtask

  task automatic send_win(input int ch, input int w[$], input bit gaps);
    foreach (w[i]) beat(w[i], i == 0, i == w.size() - 1, ch, gaps);
    release_bus();
  endtask

  task automatic wait_idle();
    do begin @(negedge clk); #1; end while (!in_ready);
    repeat (2) @(negedge clk);
    #1;
  endtask

  // R1: offer a start+end beat of full-scale samples while the record is going out
  task automatic junk_while_busy();
    @(negedge clk); #1;
    in_valid = 1; in_sample = 8'hFF; in_sow = 1; in_eow = 1; in_chan = '1;
    while (!in_ready) begin @(negedge clk); #1; end
    in_valid = 0; in_sow = 0; in_eow = 0;
  endtask

  initial begin
    int w[$];
    repeat (3) @(negedge clk);
    check(in_ready == 1 && in_ready1 == 1, "R10", "in_ready in reset", in_ready, 1);
    check(out_valid == 0 && out_valid1 == 0, "R10", "out_valid in reset", out_valid, 0);
    #1 rst_n = 1;
    @(negedge clk);
    check(in_ready == 1 && out_valid == 0, "R10", "after reset", {in_ready, out_valid}, 2'b10);

    // R8 and R4: flat window below pedestal and threshold
    phase = "R8"; thr = 100; ped = 10;
    w.delete(); for (int i = 0; i < 32; i++) w.push_back(5);
    send_win(1, w, 0); wait_idle();

    // R6: pulses incl. position 0, threshold-equal sample, last position
    phase = "R6"; w.delete();
    for (int i = 0; i < 32; i++) w.push_back(20);
    w[0] = 200; w[1] = 200; w[5] = 101; w[6] = 101; w[7] = 101; w[10] = 100;
    w[20] = 200; w[31] = 150;
    send_win(2, w, 0); wait_idle();

    // R7: 16 crossings, truncation; R1: junk offered during the record
    phase = "R7"; w.delete();
    for (int i = 0; i < 32; i++) w.push_back((i % 2 == 0) ? 255 : 0);
    send_win(3, w, 0); junk_while_busy(); wait_idle();
    phase = "R1"; w.delete(); for (int i = 0; i < 32; i++) w.push_back(i * 8);
    send_win(4, w, 0); wait_idle();

    // R7: exactly 8 crossings, no truncation
    phase = "R7"; w.delete();
    for (int i = 0; i < 32; i++) w.push_back((i < 16 && i % 2 == 0) ? 255 : 0);
    send_win(5, w, 0); wait_idle();

    // R9: aborted window followed by a restart with a new channel
    phase = "R9";
    for (int i = 0; i < 6; i++) beat(200, i == 0, 0, 7, 0);
    w.delete(); for (int i = 0; i < 32; i++) w.push_back((i == 3) ? 180 : 40);
    send_win(9, w, 0); wait_idle();
    phase = "R9"; w.delete(); w.push_back(255);
    send_win(63, w, 0); wait_idle();

    // R5: saturation boundary on the wide instance (charge x16)
    phase = "R5"; ped = 0; thr = 250;
    w.delete(); for (int i = 0; i < 32; i++) w.push_back(i < 16 ? 255 : (i == 16 ? 16 : 0));
    send_win(10, w, 0); wait_idle();
    w[16] = 15; send_win(11, w, 0); wait_idle();
    w.delete(); for (int i = 0; i < 32; i++) w.push_back(255);
    send_win(12, w, 0); wait_idle();

    // R2/R4/R6: random windows, random settings, gaps in the input
    phase = "R2";
    for (int n = 0; n < 40; n++) begin
      thr = 8'($urandom_range(0, 255)); ped = 8'($urandom_range(0, 120));
      w.delete(); for (int i = 0; i < 32; i++) w.push_back($urandom_range(0, 255));
      send_win(n % 64, w, 1);
    end
    wait_idle();
    repeat (5) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_checks++; n_fail++;
      $display("FAIL R2 watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule